// File: doc/BRIEF.md
# Fetch-Stage Next-PC Predictor

This block guesses the next fetch address for an in-order pipeline. Every cycle the fetch stage presents its program counter together with two predecode flags, and the block answers in the same cycle with a predicted next PC. The answer is taken from one of three sources, in this order: a return-address stack when the fetched instruction is flagged as a return, a direct-mapped target table when its stored tag matches the whole fetch PC, and the sequential address PC+4 otherwise.

The target table holds only redirecting branches. Each slot keeps a valid bit, the full PC of the branch as its tag, and the target. Slots are chosen by the PC bits just above the two byte-offset bits. The execute stage sends back the resolved branch PC, its real target and the target that was predicted for it. The slot is rewritten only when the two targets differ. Two branches that share a slot simply evict each other. A call flagged at fetch pushes its fall-through address onto a small circular stack. A return flagged at fetch pops that stack and uses the popped value as its prediction.

Top module: `fetch_target_predictor`

## Requirements
- R1: When the slot selected by `fetch_pc[5:2]` is valid, its stored tag equals the whole `fetch_pc`, and `fetch_ret` is low or the stack is empty, `pred_pc` equals the stored target in the same cycle.
- R2: With no matching valid slot and no usable stack prediction, `pred_pc` equals `fetch_pc + 4`, for any PC value.
- R3: When `upd_valid` is high and `upd_target` differs from `upd_pred_target`, the slot indexed by `upd_pc[5:2]` takes `upd_pc` as its tag and `upd_target` as its target. The change is visible to lookups from the next cycle on, and a lookup in the same cycle still sees the old contents.
- R4: An update with `upd_valid` low, or with `upd_target` equal to `upd_pred_target`, leaves the table unchanged. Later lookups of that PC give the earlier prediction.
- R5: Two PCs with equal bits [5:2] share one slot. The later write replaces the earlier one, so the evicted PC then predicts PC+4.
- R6: When `fetch_call` is high and `fetch_ret` is low, `fetch_pc + 4` is pushed. It becomes the top entry from the next cycle on.
- R7: When `fetch_ret` is high and the stack holds at least one entry, `pred_pc` equals the most recently pushed address, even if the table also hits. That entry is then removed.
- R8: When `fetch_ret` is high and the stack is empty, `pred_pc` follows R1 or R2 and the stack stays empty.
- R9: The stack holds 4 entries. Further pushes overwrite the oldest entry. At most 4 returns are then served, newest first, and any later return falls back as in R8.
- R10: When `fetch_call` and `fetch_ret` are both high, the instruction is treated as a return only and nothing is pushed.
- R11: While `rst_n` is low at a rising edge, every table slot is invalidated and the stack is emptied. The lookup path stays combinational during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_pc | input | 32 | PC being fetched this cycle |
| fetch_call | input | 1 | Predecode flag: fetched instruction is a call |
| fetch_ret | input | 1 | Predecode flag: fetched instruction is a return |
| pred_pc | output | 32 | Predicted next fetch PC (combinational) |
| upd_valid | input | 1 | A resolved control transfer is reported from execute |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_target | input | 32 | Actual next PC of the resolved branch |
| upd_pred_target | input | 32 | Target that was predicted for that branch at fetch |

## Verification
The prediction is combinational, so `pred_pc` is due in the same cycle as `fetch_pc` and the predecode flags. Table writes and stack pushes or pops take effect at the next rising edge and first show up in the following cycle's lookup. The bench drives every input just after a falling edge and compares `pred_pc` with its reference model a few nanoseconds later, before the rising edge. It applies the cycle's table write and stack action to the model only after that edge. A same-cycle lookup of a slot being written is therefore expected to return the old value, and the effect of a write is expected exactly one cycle later.

// File: rtl/ftp_pkg.sv
// Shared constants and types for the fetch-stage next-PC predictor.
// Assumes fixed-size instructions aligned to INSN_BYTES.
package ftp_pkg;

    // Instruction size in bytes, and the number of PC bits below the index.
    localparam int unsigned INSN_BYTES  = 4;
    localparam int unsigned OFFSET_BITS = 2;

    // Source that supplied the prediction for the current fetch.
    typedef enum logic [1:0] {
        SRC_SEQ   = 2'd0,
        SRC_TABLE = 2'd1,
        SRC_STACK = 2'd2
    } pred_src_e;

endpackage

// File: rtl/ftp_target_table.sv
// Direct-mapped table of taken-branch targets, tagged with the full PC.
// Lookup is combinational and reads the state as it was before the edge.
// The write port is applied at the rising edge. Assumes ENTRIES is a
// power of two.
module ftp_target_table
    import ftp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] rd_pc,
    output logic            rd_hit,
    output logic [PC_W-1:0] rd_target,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic [PC_W-1:0] wr_target
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic             slot_valid [ENTRIES];
    logic [PC_W-1:0]  slot_tag   [ENTRIES];
    logic [PC_W-1:0]  slot_tgt   [ENTRIES];

    assign rd_idx = rd_pc[OFFSET_BITS +: IDX_W];
    assign wr_idx = wr_pc[OFFSET_BITS +: IDX_W];

    // One storage slot per entry, each with its own write select.
    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
            logic            sel;
            logic            valid_q;
            logic [PC_W-1:0] tag_q;
            logic [PC_W-1:0] tgt_q;

            assign sel = wr_en && (wr_idx == IDX_W'(e));

            // Slot register: clear on reset, overwrite tag and target when selected.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q <= 1'b0;
                    tag_q   <= '0;
                    tgt_q   <= '0;
                end else if (sel) begin
                    valid_q <= 1'b1;
                    tag_q   <= wr_pc;
                    tgt_q   <= wr_target;
                end
            end

            assign slot_valid[e] = valid_q;
            assign slot_tag[e]   = tag_q;
            assign slot_tgt[e]   = tgt_q;
        end
    endgenerate

    // Lookup: a hit needs a valid slot whose tag equals the whole fetch PC.
    always_comb begin
        rd_hit    = slot_valid[rd_idx] && (slot_tag[rd_idx] == rd_pc);
        rd_target = slot_tgt[rd_idx];
    end

endmodule

// File: rtl/ftp_return_stack.sv
// Circular return-address stack. wr_ptr names the next free slot, and
// level counts live entries up to DEPTH. A push onto a full stack
// overwrites the oldest entry and leaves the level at DEPTH. A pop is
// honoured only when the level is non-zero. Pop wins over push; the
// caller keeps the two exclusive.
module ftp_return_stack #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [PC_W-1:0]              push_addr,
    input  logic                         pop,
    output logic [PC_W-1:0]              top_addr,
    output logic [$clog2(DEPTH+1)-1:0]   level
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] FULL_LVL  = LVL_W'(DEPTH);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] top_ptr;
    logic [PTR_W-1:0] next_ptr;
    logic [LVL_W-1:0] level_q;
    logic             do_pop;
    logic             do_push;
    logic [PC_W-1:0]  slot_data [DEPTH];

    // Pointer arithmetic with explicit wrap, so any DEPTH works.
    always_comb begin
        top_ptr  = (wr_ptr == '0) ? LAST_SLOT : wr_ptr - 1'b1;
        next_ptr = (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
        do_pop   = pop && (level_q != '0);
        do_push  = push && !pop;
    end

    // One address register per slot, written when the pointer selects it.
    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_slot
            logic [PC_W-1:0] data_q;

            // Slot register: capture the pushed address.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    data_q <= '0;
                end else if (do_push && (wr_ptr == PTR_W'(s))) begin
                    data_q <= push_addr;
                end
            end

            assign slot_data[s] = data_q;
        end
    endgenerate

    // Pointer and occupancy: step back on pop, forward on push, saturate the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            level_q <= '0;
        end else if (do_pop) begin
            wr_ptr  <= top_ptr;
            level_q <= level_q - 1'b1;
        end else if (do_push) begin
            wr_ptr <= next_ptr;
            if (level_q != FULL_LVL) begin
                level_q <= level_q + 1'b1;
            end
        end
    end

    assign top_addr = slot_data[top_ptr];
    assign level    = level_q;

endmodule

// File: rtl/ftp_next_select.sv
// Chooses the predicted next PC and steers the stack controls.
// Priority: stack on a flagged return with live entries, then a table
// hit, then the sequential address. A fetch flagged as both call and
// return counts as a return only.
module ftp_next_select
    import ftp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int LVL_W = 3
) (
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic             is_call,
    input  logic             is_ret,
    input  logic             tbl_hit,
    input  logic [PC_W-1:0]  tbl_target,
    input  logic [LVL_W-1:0] stk_level,
    input  logic [PC_W-1:0]  stk_top,
    output logic             push_en,
    output logic             pop_en,
    output logic [PC_W-1:0]  push_addr,
    output logic [PC_W-1:0]  pred_pc
);

    logic            stk_live;
    logic [PC_W-1:0] seq_pc;
    pred_src_e       src;

    // Sequential fall-through address and stack occupancy test.
    always_comb begin
        seq_pc   = fetch_pc + PC_W'(INSN_BYTES);
        stk_live = (stk_level != '0);
    end

    // Source priority: live return stack, then tagged table hit, then fall-through.
    always_comb begin
        if (is_ret && stk_live) begin
            src = SRC_STACK;
        end else if (tbl_hit) begin
            src = SRC_TABLE;
        end else begin
            src = SRC_SEQ;
        end
    end

    // Prediction mux driven by the selected source.
    always_comb begin
        case (src)
            SRC_STACK: pred_pc = stk_top;
            SRC_TABLE: pred_pc = tbl_target;
            default:   pred_pc = seq_pc;
        endcase
    end

    // Stack steering: returns pop when possible, pure calls push their fall-through.
    always_comb begin
        pop_en    = is_ret && stk_live;
        push_en   = is_call && !is_ret;
        push_addr = seq_pc;
    end

endmodule

// File: rtl/fetch_target_predictor.sv
// Top of the fetch-stage next-PC predictor. Lookup is fully
// combinational from fetch_pc and the predecode flags. The execute-stage
// update and the stack push or pop take effect at the next rising edge.
// Assumes that at most one fetch is presented per cycle and that
// wrong-path fetches are not filtered here.
module fetch_target_predictor
    import ftp_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int ENTRIES   = 16,
    parameter int RAS_DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            fetch_call,
    input  logic            fetch_ret,
    output logic [PC_W-1:0] pred_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target,
    input  logic [PC_W-1:0] upd_pred_target
);

    localparam int LVL_W = $clog2(RAS_DEPTH + 1);

    logic             tbl_hit;
    logic [PC_W-1:0]  tbl_target;
    logic             tbl_wr;
    logic             stk_push;
    logic             stk_pop;
    logic [PC_W-1:0]  stk_push_addr;
    logic [PC_W-1:0]  stk_top;
    logic [LVL_W-1:0] stk_level;

    // Write only when execute found the fetch-time guess wrong.
    always_comb begin
        tbl_wr = upd_valid && (upd_target != upd_pred_target);
    end

    ftp_target_table #(
        .PC_W    (PC_W),
        .ENTRIES (ENTRIES)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pc     (fetch_pc),
        .rd_hit    (tbl_hit),
        .rd_target (tbl_target),
        .wr_en     (tbl_wr),
        .wr_pc     (upd_pc),
        .wr_target (upd_target)
    );

    ftp_return_stack #(
        .PC_W  (PC_W),
        .DEPTH (RAS_DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (stk_push),
        .push_addr (stk_push_addr),
        .pop       (stk_pop),
        .top_addr  (stk_top),
        .level     (stk_level)
    );

    ftp_next_select #(
        .PC_W  (PC_W),
        .LVL_W (LVL_W)
    ) u_select (
        .fetch_pc   (fetch_pc),
        .is_call    (fetch_call),
        .is_ret     (fetch_ret),
        .tbl_hit    (tbl_hit),
        .tbl_target (tbl_target),
        .stk_level  (stk_level),
        .stk_top    (stk_top),
        .push_en    (stk_push),
        .pop_en     (stk_pop),
        .push_addr  (stk_push_addr),
        .pred_pc    (pred_pc)
    );

endmodule

// File: rtl/ftp_checker.sv
// Temporal checks for the next-PC predictor. Bound to the top module.
// It observes ports plus the stack occupancy.
module ftp_checker #(
    parameter int PC_W      = 32,
    parameter int RAS_DEPTH = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [PC_W-1:0]                fetch_pc,
    input logic                           fetch_call,
    input logic                           fetch_ret,
    input logic [PC_W-1:0]                pred_pc,
    input logic                           upd_valid,
    input logic [PC_W-1:0]                upd_pc,
    input logic [PC_W-1:0]                upd_target,
    input logic [PC_W-1:0]                upd_pred_target,
    input logic [$clog2(RAS_DEPTH+1)-1:0] stk_level
);

    localparam int LVL_W = $clog2(RAS_DEPTH + 1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(RAS_DEPTH);

    // R3
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_target != upd_pred_target)) |=>
            (!(fetch_pc == $past(upd_pc) && !fetch_ret) || (pred_pc == $past(upd_target))));

    // R7
    push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_call && !fetch_ret) |=>
            (!fetch_ret || (pred_pc == $past(fetch_pc) + PC_W'(4))));

    // R9
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_call && !fetch_ret) |=>
            (stk_level == (($past(stk_level) == FULL_LVL) ? FULL_LVL : $past(stk_level) + 1'b1)));

    // R7
    pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ret && (stk_level != '0)) |=> (stk_level == $past(stk_level) - 1'b1));

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ret && (stk_level == '0)) |=> (stk_level == '0));

    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ((stk_level == '0) && (fetch_ret || (pred_pc == fetch_pc + PC_W'(4)))));

endmodule

bind fetch_target_predictor ftp_checker #(
    .PC_W      (PC_W),
    .RAS_DEPTH (RAS_DEPTH)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_pc        (fetch_pc),
    .fetch_call      (fetch_call),
    .fetch_ret       (fetch_ret),
    .pred_pc         (pred_pc),
    .upd_valid       (upd_valid),
    .upd_pc          (upd_pc),
    .upd_target      (upd_target),
    .upd_pred_target (upd_pred_target),
    .stk_level       (stk_level)
);

// File: tb/fetch_target_predictor_tb.sv
// Bench: a behavioural reference (associative arrays and a queue) is
// compared with pred_pc on every cycle.
module fetch_target_predictor_tb;

    localparam int PC_W    = 32;
    localparam int ENTRIES = 16;
    localparam int DEPTH   = 4;
    localparam int HALF    = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            fetch_call = 1'b0;
    logic            fetch_ret = 1'b0;
    logic [PC_W-1:0] pred_pc;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic [PC_W-1:0] upd_target = '0;
    logic [PC_W-1:0] upd_pred_target = '0;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    logic [31:0] m_tag [int];
    logic [31:0] m_tgt [int];
    logic [31:0] m_stk [$];

    always #HALF clk = ~clk;

    fetch_target_predictor #(
        .PC_W      (PC_W),
        .ENTRIES   (ENTRIES),
        .RAS_DEPTH (DEPTH)
    ) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .fetch_pc        (fetch_pc),
        .fetch_call      (fetch_call),
        .fetch_ret       (fetch_ret),
        .pred_pc         (pred_pc),
        .upd_valid       (upd_valid),
        .upd_pc          (upd_pc),
        .upd_target      (upd_target),
        .upd_pred_target (upd_pred_target)
    );

    function automatic int slot_of(logic [31:0] pc);
        return int'((pc >> 2) % ENTRIES);
    endfunction

    function automatic logic [31:0] model_pred(logic [31:0] pc, logic rt);
        int k;
        k = slot_of(pc);
        if (rt && (m_stk.size() > 0)) return m_stk[m_stk.size() - 1];
        if (m_tag.exists(k) && (m_tag[k] == pc)) return m_tgt[k];
        return pc + 32'd4;
    endfunction

    // One cycle: drive after the falling edge, compare, then advance the model.
    task automatic step(input logic r, input logic [31:0] pc, input logic c,
                        input logic rt, input logic uv, input logic [31:0] upc,
                        input logic [31:0] utgt, input logic [31:0] upred,
                        input string req);
        logic [31:0] exp_pc;
        rst_n = r; fetch_pc = pc; fetch_call = c; fetch_ret = rt;
        upd_valid = uv; upd_pc = upc; upd_target = utgt; upd_pred_target = upred;
        #2;
        exp_pc = model_pred(pc, rt);
        checks++;
        if (pred_pc !== exp_pc) begin
            errors++;
            $display("FAIL %s: pc=%h pred_pc actual %h expected %h", req, pc, pred_pc, exp_pc);
        end
        @(posedge clk);
        if (!r) begin
            m_tag.delete(); m_tgt.delete(); m_stk.delete();
        end else begin
            if (uv && (utgt != upred)) begin
                m_tag[slot_of(upc)] = upc;
                m_tgt[slot_of(upc)] = utgt;
            end
            if (rt) begin
                if (m_stk.size() > 0) void'(m_stk.pop_back());
            end else if (c) begin
                m_stk.push_back(pc + 32'd4);
                if (m_stk.size() > DEPTH) void'(m_stk.pop_front());
            end
        end
        @(negedge clk);
    endtask

    task automatic look(input logic [31:0] pc, input logic c, input logic rt, input string req);
        step(1'b1, pc, c, rt, 1'b0, 32'h0, 32'h0, 32'h0, req);
    endtask

    task automatic look_upd(input logic [31:0] pc, input logic [31:0] upc,
                            input logic [31:0] utgt, input logic [31:0] upred, input string req);
        step(1'b1, pc, 1'b0, 1'b0, 1'b1, upc, utgt, upred, req);
    endtask

    localparam logic [31:0] PA = 32'h0000_1000;
    localparam logic [31:0] PB = 32'h0000_1040;  // same slot as PA
    localparam logic [31:0] T1 = 32'h0000_2000;
    localparam logic [31:0] T2 = 32'h0000_3000;
    localparam logic [31:0] T3 = 32'h0000_4000;

    initial begin
        // Settle reset without checking (state unknown before the first edge).
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        // R11: reset held, table empty, stack empty
        step(1'b0, PA, 1'b0, 1'b0, 1'b0, 0, 0, 0, "R11");
        step(1'b0, PB, 1'b0, 1'b1, 1'b0, 0, 0, 0, "R11");
        // R2: misses after reset
        look(PA, 1'b0, 1'b0, "R2");
        look(32'h1234_5678, 1'b0, 1'b0, "R2");
        // R3: write; same-cycle lookup sees old, next cycle sees new
        look_upd(PA, PA, T1, PA + 32'd4, "R3");
        // R1: tagged hit
        look(PA, 1'b0, 1'b0, "R1");
        // R4: matching targets leave the table alone
        look_upd(PA, PA, T2, T2, "R4");
        look(PA, 1'b0, 1'b0, "R4");
        // R4: update not valid is ignored
        step(1'b1, 32'h500, 1'b0, 1'b0, 1'b0, PA, T3, T1, "R4");
        look(PA, 1'b0, 1'b0, "R4");
        // R5: aliasing replacement
        look_upd(PB, PB, T3, PB + 32'd4, "R5");
        look(PB, 1'b0, 1'b0, "R5");
        look(PA, 1'b0, 1'b0, "R5");
        // R6 / R7: nested calls and returns
        look(32'h100, 1'b1, 1'b0, "R6");
        look(32'h200, 1'b1, 1'b0, "R6");
        look(32'h300, 1'b0, 1'b1, "R7");
        look(32'h300, 1'b0, 1'b1, "R7");
        // R8: return on empty stack uses table, then sequential
        look(PB, 1'b0, 1'b1, "R8");
        look(32'h300, 1'b0, 1'b1, "R8");
        // R7: stack overrides a table hit
        look(32'h600, 1'b1, 1'b0, "R7");
        look(PB, 1'b0, 1'b1, "R7");
        look(PB, 1'b0, 1'b0, "R1");
        // R9: overflow wraps, newest four survive
        for (int i = 1; i <= DEPTH + 2; i++) look(32'h10 * i, 1'b1, 1'b0, "R9");
        for (int i = 0; i <= DEPTH; i++) look(32'hC00, 1'b0, 1'b1, "R9");
        // R10: call and return together act as return only
        look(32'h700, 1'b1, 1'b0, "R10");
        look(32'h800, 1'b1, 1'b1, "R10");
        look(32'h900, 1'b0, 1'b1, "R10");
        // R11: mid-run reset clears table and stack
        look(32'hA00, 1'b1, 1'b0, "R11");
        step(1'b0, PB, 1'b0, 1'b0, 1'b0, 0, 0, 0, "R11");
        look(PB, 1'b0, 1'b0, "R11");
        look(32'hB00, 1'b0, 1'b1, "R11");
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(2 * HALF * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule